// File: doc/BRIEF.md
# Per-Processor Counter-Timer Array

This block is a bus-mapped timer unit. It holds one system counter-timer and up to four per-processor counter-timers, and each timer drives its own interrupt line. Every per-processor timer runs a small state machine with three states. `MODE_LIMIT` is a 32-bit counter that restarts at a programmed limit. `MODE_USER_IDLE` is a stopped 64-bit user counter, and `MODE_USER_RUN` is that counter running. Software picks the mode of each processor's timer through one bit per processor in a shared configuration register.

The transitions are as follows. `LIMIT->USER_IDLE` happens when a processor's configuration bit goes from 0 to 1. `USER_IDLE->USER_RUN` and `USER_RUN->USER_IDLE` happen on writes of 1 and 0 to that timer's control register. `USER_*->LIMIT` happens when the configuration bit goes from 1 to 0. In a multiprocessor build (`SMP_EN=1`) each of the four slots has its own timer. In a uniprocessor build (`SMP_EN=0`) only one timer exists, and the slot field of the address is ignored, so every per-processor window reaches that one timer.

All counters advance only on cycles where `tick` is high. A read returns its data on `bus_rdata` one clock after the read strobe.

Top module: `ct_timer_array`

## Requirements
- R1: The address is split as {slot[2:0], reg[1:0]}. Slots 0 to 3 are the per-processor timers and slot 4 is the system timer. Each per-processor timer drives only its own `cpu_irq` bit.
- R2: With `SMP_EN=0`, all of slots 0 to 3 reach the same single timer. Its interrupt is `cpu_irq[0]`, `cpu_irq[3:1]` stay 0, and only bit 0 of the configuration register can be set.
- R3: In limit mode, a write to reg 0 (limit) stores the limit, sets the count to 0 and deasserts the interrupt.
- R4: In limit mode, the count goes up by one per tick. On the tick where count+1 equals a nonzero limit, the count returns to 0, the interrupt asserts and the reached flag sets. The reached flag reads as bit 0 of reg 2.
- R5: A limit of 0 means free-run: the 32-bit count wraps only after all ones, and no interrupt is raised before that.
- R6: A read of reg 0 acknowledges the timer: its interrupt deasserts, and in limit mode its reached flag clears. In user mode, reg 0 reads as all ones and writes to it are ignored.
- R7: Slot 4, reg 3 is the configuration register. Bit i = 1 puts timer i in user mode and bit i = 0 puts it in limit mode. It reads back the current modes and is 0 after reset.
- R8: On a 0-to-1 mode change, the timer's interrupt deasserts, the timer enters the stopped user state and its 64-bit count is 0. While stopped, ticks leave the count unchanged.
- R9: On a 1-to-0 mode change, the user counter stops and the limit counter restarts from 0 and runs, keeping its stored limit.
- R10: In user mode, a write to reg 1 loads count[31:0], keeps count[63:32], clears the reached flag and deasserts the interrupt.
- R11: In user mode, a write to reg 2 loads count[63:32] and clears the reached flag. The interrupt is left as it is.
- R12: In user mode, a write of bit 0 to reg 3 runs (1) or stops (0) the counter. Reg 3 reads as {reached, running}. When a running count reaches all ones, reached sets and the interrupt asserts.
- R13: In user mode, a read of reg 2 returns count[63:32] and latches count[31:0]. The next reg 1 read returns the latched word; later reg 1 reads return the live count.
- R14: The system timer (slot 4) behaves as a limit-mode timer on regs 0 and 1, with its own `sys_irq`, and reg 0 reads acknowledge it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for all timers |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | {slot, reg} address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| sys_irq | output | 1 | System timer interrupt |
| cpu_irq | output | 4 | Per-processor timer interrupts |

## Verification
The limit counter is tried with a small nonzero limit, which shows whether the restart happens at count+1 equal to the limit or one tick late. It is also tried with a zero limit, which must not raise an interrupt early. The user counter is loaded just below a 32-bit carry and just below all ones. This tells apart a correct 64-bit carry, a latched versus live low word, and a reached event that fires exactly at all ones. Writes of the limit while in user mode, and ticks while stopped, show that ignored stimulus leaves state untouched. A uniprocessor instance accessed through different slots shows whether the alias works.

// File: rtl/ct_pkg.sv
package ct_pkg;
    typedef enum logic [1:0] {
        MODE_LIMIT     = 2'd0,
        MODE_USER_IDLE = 2'd1,
        MODE_USER_RUN  = 2'd2
    } ct_state_e;

    localparam logic [1:0] REG_LIMIT  = 2'd0;
    localparam logic [1:0] REG_CNT_LO = 2'd1;
    localparam logic [1:0] REG_CNT_HI = 2'd2;
    localparam logic [1:0] REG_CTRL   = 2'd3;
endpackage

// File: rtl/ct_sys_timer.sv
module ct_sys_timer
    import ct_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr,
    input  logic          rd,
    input  logic [1:0]    sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rval,
    output logic          irq
);
    logic [DW-1:0] lim_q;
    logic [DW-1:0] cnt_q;
    logic          irq_q;
    logic          wrap;

    assign wrap = (lim_q == '0) ? (cnt_q == '1) : ((cnt_q + 1'b1) == lim_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q <= '0;
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else if (wr && sel == REG_LIMIT) begin
            lim_q <= wdata;
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (tick) begin
                if (wrap) begin
                    cnt_q <= '0;
                    irq_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            if (rd && sel == REG_LIMIT) irq_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            REG_LIMIT:  rval = lim_q;
            REG_CNT_LO: rval = cnt_q;
            default:    rval = '0;
        endcase
    end

    assign irq = irq_q;

    // R14
    sys_irq_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(tick));
endmodule

// File: rtl/ct_cpu_timer.sv
module ct_cpu_timer
    import ct_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr,
    input  logic          rd,
    input  logic [1:0]    sel,
    input  logic [DW-1:0] wdata,
    input  logic          mode_wr,
    input  logic          mode_bit,
    output logic [DW-1:0] rval,
    output logic          irq,
    output logic          user_mode
);
    localparam int CW = 2 * DW;

    ct_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] lim_q;
    logic [DW-1:0] snap_q;
    logic          snap_v_q;
    logic          reached_q;
    logic          irq_q;
    logic          is_user, enter_user, enter_limit, ctrl_wr;
    logic          lim_wrap, user_top;

    assign is_user     = (state_q != MODE_LIMIT);
    assign ctrl_wr     = wr && sel == REG_CTRL;
    assign enter_user  = !is_user && state_d != MODE_LIMIT;
    assign enter_limit = is_user && state_d == MODE_LIMIT;
    assign lim_wrap    = (lim_q == '0) ? (cnt_q[DW-1:0] == '1)
                                       : ((cnt_q[DW-1:0] + 1'b1) == lim_q);
    assign user_top    = (cnt_q == {{(CW-1){1'b1}}, 1'b0});

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_LIMIT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_LIMIT:
                if (mode_wr && mode_bit) state_d = MODE_USER_IDLE;
            MODE_USER_IDLE:
                if (mode_wr && !mode_bit)      state_d = MODE_LIMIT;
                else if (ctrl_wr && wdata[0])  state_d = MODE_USER_RUN;
            MODE_USER_RUN:
                if (mode_wr && !mode_bit)      state_d = MODE_LIMIT;
                else if (ctrl_wr && !wdata[0]) state_d = MODE_USER_IDLE;
            default:
                state_d = MODE_LIMIT;
        endcase
    end

    // counting datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            lim_q     <= '0;
            snap_q    <= '0;
            snap_v_q  <= 1'b0;
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
        end else if (enter_user || enter_limit) begin
            cnt_q     <= '0;
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
            snap_v_q  <= 1'b0;
        end else if (!is_user) begin
            if (wr && sel == REG_LIMIT) begin
                lim_q     <= wdata;
                cnt_q     <= '0;
                irq_q     <= 1'b0;
                reached_q <= 1'b0;
            end else begin
                if (tick) begin
                    if (lim_wrap) begin
                        cnt_q     <= '0;
                        irq_q     <= 1'b1;
                        reached_q <= 1'b1;
                    end else begin
                        cnt_q[DW-1:0] <= cnt_q[DW-1:0] + 1'b1;
                    end
                end
                if (rd && sel == REG_LIMIT) begin
                    irq_q     <= 1'b0;
                    reached_q <= 1'b0;
                end
            end
        end else begin
            if (wr && sel == REG_CNT_LO) begin
                cnt_q[DW-1:0] <= wdata;
                reached_q     <= 1'b0;
                irq_q         <= 1'b0;
                snap_v_q      <= 1'b0;
            end else if (wr && sel == REG_CNT_HI) begin
                cnt_q[CW-1:DW] <= wdata;
                reached_q      <= 1'b0;
                snap_v_q       <= 1'b0;
            end else begin
                if (state_q == MODE_USER_RUN && tick) begin
                    cnt_q <= cnt_q + 1'b1;
                    if (user_top) begin
                        reached_q <= 1'b1;
                        irq_q     <= 1'b1;
                    end
                end
                if (rd && sel == REG_LIMIT) irq_q <= 1'b0;
                if (rd && sel == REG_CNT_HI) begin
                    snap_q   <= cnt_q[DW-1:0];
                    snap_v_q <= 1'b1;
                end else if (rd && sel == REG_CNT_LO) begin
                    snap_v_q <= 1'b0;
                end
            end
        end
    end

    // read outputs
    always_comb begin
        unique case (sel)
            REG_LIMIT:  rval = is_user ? '1 : lim_q;
            REG_CNT_LO: rval = (is_user && snap_v_q) ? snap_q : cnt_q[DW-1:0];
            REG_CNT_HI: rval = is_user ? cnt_q[CW-1:DW] : {{(DW-1){1'b0}}, reached_q};
            default:    rval = {{(DW-2){1'b0}}, reached_q, state_q != MODE_USER_IDLE};
        endcase
    end

    assign irq       = irq_q;
    assign user_mode = is_user;

    // R3
    lim_wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_user && !mode_wr && wr && sel == REG_LIMIT)
        |=> (cnt_q == '0 && !irq_q && lim_q == $past(wdata)));
    // R8
    user_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_user && mode_wr && mode_bit)
        |=> (state_q == MODE_USER_IDLE && !irq_q && cnt_q == '0));
    // R8
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_USER_IDLE && !wr && !mode_wr) |=> $stable(cnt_q));
    // R10
    lo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_user && !mode_wr && wr && sel == REG_CNT_LO)
        |=> (!reached_q && !irq_q && cnt_q[DW-1:0] == $past(wdata)));
endmodule

// File: rtl/ct_timer_array.sv
module ct_timer_array
    import ct_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter bit SMP_EN    = 1'b1,
    parameter int DW        = 32,
    parameter int SLOT_W    = $clog2(NUM_SLOTS + 1),
    parameter int ADDR_W    = SLOT_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    output logic                 sys_irq,
    output logic [NUM_SLOTS-1:0] cpu_irq
);
    localparam int N_TMR = SMP_EN ? NUM_SLOTS : 1;

    logic [SLOT_W-1:0]    slot;
    logic [1:0]           rsel;
    logic                 sys_hit, cpu_hit, cfg_wr;
    logic [NUM_SLOTS-1:0] hit;
    logic [NUM_SLOTS-1:0] user_bits;
    logic [DW-1:0]        tmr_rval [NUM_SLOTS];
    logic [DW-1:0]        sys_rval;
    logic [DW-1:0]        rmux;
    logic [DW-1:0]        rdata_q;

    assign slot    = bus_addr[ADDR_W-1:2];
    assign rsel    = bus_addr[1:0];
    assign sys_hit = (slot == SLOT_W'(NUM_SLOTS));
    assign cpu_hit = (slot < SLOT_W'(NUM_SLOTS));
    assign cfg_wr  = bus_wr && sys_hit && rsel == REG_CTRL;

    ct_sys_timer #(.DW(DW)) u_sys (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wr    (bus_wr && sys_hit),
        .rd    (bus_rd && sys_hit),
        .sel   (rsel),
        .wdata (bus_wdata),
        .rval  (sys_rval),
        .irq   (sys_irq)
    );

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        if (i < N_TMR) begin : g_tmr
            assign hit[i] = cpu_hit && ((N_TMR == 1) || slot == SLOT_W'(i));
            ct_cpu_timer #(.DW(DW)) u_tmr (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick      (tick),
                .wr        (bus_wr && hit[i]),
                .rd        (bus_rd && hit[i]),
                .sel       (rsel),
                .wdata     (bus_wdata),
                .mode_wr   (cfg_wr),
                .mode_bit  (bus_wdata[i]),
                .rval      (tmr_rval[i]),
                .irq       (cpu_irq[i]),
                .user_mode (user_bits[i])
            );
        end else begin : g_empty
            assign hit[i]       = 1'b0;
            assign tmr_rval[i]  = '0;
            assign cpu_irq[i]   = 1'b0;
            assign user_bits[i] = 1'b0;
        end
    end

    always_comb begin
        rmux = '0;
        if (sys_hit) begin
            rmux = (rsel == REG_CTRL) ? {{(DW-NUM_SLOTS){1'b0}}, user_bits} : sys_rval;
        end else begin
            for (int k = 0; k < NUM_SLOTS; k++) begin
                if (hit[k]) rmux = tmr_rval[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rmux;
    end

    assign bus_rdata = rdata_q;

    // R2
    up_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (N_TMR == 1) |-> (cpu_irq[NUM_SLOTS-1:1] == '0));
    // R1
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: tb/ct_timer_array_tb.sv
`timescale 1ns/1ps
module ct_timer_array_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_smp, rdata_up;
    logic        sirq_smp, sirq_up;
    logic [3:0]  irq_smp, irq_up;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    bit          up_q[$];
    string       tag_q[$];
    logic        rd_fired = 1'b0;

    always #4 clk = ~clk;

    ct_timer_array #(.SMP_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_smp),
        .sys_irq(sirq_smp), .cpu_irq(irq_smp));

    ct_timer_array #(.SMP_EN(1'b0)) dut_up_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_up),
        .sys_irq(sirq_up), .cpu_irq(irq_up));

    function automatic logic [4:0] ad(input int s, input int r);
        return 5'((s << 2) | r);
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard once per completed read
    always @(posedge clk) rd_fired <= bus_rd;
    always @(negedge clk) begin
        if (rd_fired && exp_q.size() > 0) begin
            logic [31:0] e;
            bit u;
            string t;
            e = exp_q.pop_front();
            u = up_q.pop_front();
            t = tag_q.pop_front();
            chk(u ? rdata_up : rdata_smp, e, t);
        end
    end

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input bit up, input string t);
        @(negedge clk);
        bus_addr = a;
        bus_rd = 1'b1;
        exp_q.push_back(e);
        up_q.push_back(up);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state (R7)
        chk({28'd0, irq_smp}, 32'd0, "R7 reset cpu_irq");
        chk({31'd0, sirq_smp}, 32'd0, "R7 reset sys_irq");
        rd(ad(4, 3), 32'd0, 0, "R7 reset config");
        rd(ad(0, 0), 32'd0, 0, "R5 reset limit zero");

        // limit mode on slot 1 (R3, R4, R1)
        wr(ad(1, 0), 32'd3);
        ticks(2);
        chk({28'd0, irq_smp}, 32'd0, "R4 no irq before limit");
        rd(ad(1, 1), 32'd2, 0, "R4 count after 2 ticks");
        ticks(1);
        chk({28'd0, irq_smp}, 32'h2, "R1 only slot1 irq");
        rd(ad(1, 2), 32'd1, 0, "R4 reached flag");
        rd(ad(1, 1), 32'd0, 0, "R4 count restarted");
        rd(ad(1, 0), 32'd3, 0, "R3 limit stored");
        chk({31'd0, irq_smp[1]}, 32'd0, "R6 ack clears irq");
        rd(ad(1, 2), 32'd0, 0, "R6 ack clears reached");

        // free-run with zero limit (R5)
        rd(ad(0, 1), 32'd3, 0, "R5 zero limit counts on");
        chk({31'd0, irq_smp[0]}, 32'd0, "R5 no early irq");

        // limit write resets count (R3)
        ticks(2);
        wr(ad(1, 0), 32'd5);
        rd(ad(1, 1), 32'd0, 0, "R3 count reset by limit write");

        // system timer (R14)
        wr(ad(4, 0), 32'd2);
        ticks(1);
        chk({31'd0, sirq_smp}, 32'd0, "R14 sys before limit");
        ticks(1);
        chk({31'd0, sirq_smp}, 32'd1, "R14 sys irq");
        rd(ad(4, 0), 32'd2, 0, "R14 sys limit");
        chk({31'd0, sirq_smp}, 32'd0, "R14 sys ack");

        // enter user mode on slot 2 (R7, R8)
        wr(ad(4, 3), 32'h4);
        rd(ad(4, 3), 32'h4, 0, "R7 config readback");
        rd(ad(2, 3), 32'd0, 0, "R8 stopped after entry");
        ticks(3);
        rd(ad(2, 1), 32'd0, 0, "R8 stopped count holds");

        // 64-bit carry and coherent read (R10, R11, R12, R13)
        wr(ad(2, 2), 32'h1);
        wr(ad(2, 1), 32'hFFFF_FFFE);
        wr(ad(2, 3), 32'h1);
        ticks(1);
        rd(ad(2, 2), 32'h1, 0, "R13 high word");
        ticks(1);
        rd(ad(2, 1), 32'hFFFF_FFFF, 0, "R13 latched low word");
        rd(ad(2, 1), 32'h0, 0, "R13 live low word");

        wr(ad(2, 2), 32'hFFFF_FFFF);
        wr(ad(2, 1), 32'hFFFF_FFFD);
        ticks(1);
        chk({31'd0, irq_smp[2]}, 32'd0, "R12 no irq below max");
        ticks(1);
        chk({31'd0, irq_smp[2]}, 32'd1, "R12 irq at all ones");
        rd(ad(2, 3), 32'd3, 0, "R12 reached and running");
        wr(ad(2, 2), 32'hFFFF_FFFF);
        rd(ad(2, 3), 32'd1, 0, "R11 high write clears reached");
        chk({31'd0, irq_smp[2]}, 32'd1, "R11 high write keeps irq");
        wr(ad(2, 1), 32'd5);
        chk({31'd0, irq_smp[2]}, 32'd0, "R10 low write clears irq");
        rd(ad(2, 2), 32'hFFFF_FFFF, 0, "R10 high word kept");
        rd(ad(2, 1), 32'd5, 0, "R10 low word loaded");

        wr(ad(2, 0), 32'd7);
        rd(ad(2, 0), 32'hFFFF_FFFF, 0, "R6 user limit write ignored");

        // back to limit mode (R9)
        wr(ad(4, 3), 32'h0);
        ticks(2);
        rd(ad(2, 1), 32'd2, 0, "R9 limit counter runs from 0");
        rd(ad(2, 0), 32'd0, 0, "R9 stored limit kept");
        rd(ad(4, 3), 32'd0, 0, "R7 config cleared");

        // uniprocessor alias (R2)
        wr(ad(3, 0), 32'd2);
        rd(ad(0, 0), 32'd2, 1, "R2 alias slot0");
        rd(ad(1, 0), 32'd2, 1, "R2 alias slot1");
        ticks(2);
        chk({28'd0, irq_up}, 32'h1, "R2 single irq line");
        rd(ad(2, 0), 32'd2, 1, "R2 alias slot2 ack");
        chk({28'd0, irq_up}, 32'h0, "R2 ack via alias");
        wr(ad(4, 3), 32'hF);
        rd(ad(4, 3), 32'h1, 1, "R2 config one bit");
        rd(ad(4, 3), 32'hF, 0, "R7 config four bits");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard: actual=%0d expected=0 pending", exp_q.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule